// File: doc/BRIEF.md
# Dual Interval Timer with Sticky Status Flags

This block holds two independent interval timers, A and B, for a sound-generator style peripheral. Each timer keeps an accumulator of elapsed time. The accumulator advances by 64 units for every count delivered on a shared tick input. When the accumulator reaches the programmed period, the period is subtracted and the overshoot is kept. The next interval therefore starts from the remainder, so long-run timing stays exact even when tick counts arrive in bursts.

A host writes the two periods, a mode word and flag-clear strobes over a small write port. It reads an 8-bit status byte that holds one sticky overflow flag per timer. A single interrupt level follows the flags through a two-state machine. `IRQ_QUIET` moves to `IRQ_RAISED` when any flag is set. `IRQ_RAISED` returns to `IRQ_QUIET` once all flags are clear. In both cases the move happens one cycle after the flags change.

Top module: `dual_ival_timer`

## Requirements
- R1: Mode bit 0 lets timer A run and mode bit 1 lets timer B run. A timer whose run bit is clear keeps its accumulator unchanged and never overflows. When it runs again, it resumes from the held value.
- R2: Mode bit 2 lets an overflow of timer A set status bit 0, and mode bit 3 does the same for timer B and status bit 1. With the enable clear, the timer still wraps but its flag stays unchanged.
- R3: In every cycle where tick_n is nonzero, each running timer adds 64 × tick_n to its accumulator.
- R4: When the sum reaches or exceeds the timer's period, the period is subtracted once and the remainder is kept. The accumulator is not zeroed.
- R5: status_o carries timer A's flag in bit 0 and timer B's flag in bit 1, with bits 7:2 zero. A flag stays set until the host clears it.
- R6: A cycle with tick_n = 0 leaves both accumulators unchanged, and no flag can be set in it.
- R7: A write to address 2 with bit 4 set clears status bit 0, and bit 5 clears status bit 1, at the same clock edge. If an overflow sets the same flag in that cycle, the flag ends up set.
- R8: Writes to address 0 and address 1 load the 16-bit periods of A and B. Writes to address 2 load mode bits 3:0. A value written in a cycle is first used by the tick of the following cycle. Writes to address 3 are ignored.
- R9: irq_o is high exactly when either status bit was set one cycle earlier.
- R10: Reset clears both accumulators, both periods, the mode bits, the status flags and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Write address: 0 period A, 1 period B, 2 mode/clear |
| wr_data | input | 16 | Write data |
| tick_n | input | 4 | Tick count for this cycle, 0 means no tick |
| status_o | output | 8 | Status byte, bit 0 timer A flag, bit 1 timer B flag |
| irq_o | output | 1 | Interrupt level |

## Verification
The bench builds the block with its defaults: 16-bit periods, a 4-bit tick count and a 64-unit step. These values let a single tick of 15 (960 units) approach a 1000-unit period. They also let a short period of 200 overflow after a few unit ticks, so carried remainders show up as an earlier next overflow. A model of both accumulators in the bench predicts the status byte and interrupt level after every edge. It covers flag suppression, paused timers, a clear that collides with an overflow, and a period rewrite on the same edge as a tick.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int NUM_TMR = 2;

    typedef logic [1:0] addr_t;
    localparam addr_t ADDR_PER_A = 2'd0;
    localparam addr_t ADDR_PER_B = 2'd1;
    localparam addr_t ADDR_MODE  = 2'd2;

    // mode word field positions
    localparam int MB_RUN_LO = 0;   // run A, run B
    localparam int MB_FLG_LO = 2;   // flag enable A, B
    localparam int MB_CLR_LO = 4;   // clear strobe A, B
    localparam int MODE_W    = 4;   // stored mode bits

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/dit_host_regs.sv
module dit_host_regs
    import dit_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  addr_t                           wr_addr,
    input  logic [PER_W-1:0]                wr_data,
    output logic [NUM_TMR-1:0][PER_W-1:0]   period_o,
    output logic [NUM_TMR-1:0]              run_o,
    output logic [NUM_TMR-1:0]              flag_en_o,
    output logic [NUM_TMR-1:0]              clr_o
);
    logic [MODE_W-1:0]              mode_q;
    logic [NUM_TMR-1:0][PER_W-1:0]  period_q;
    logic                           mode_wr;

    assign mode_wr = wr_en && (wr_addr == ADDR_MODE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            period_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_PER_A: period_q[0] <= wr_data;
                ADDR_PER_B: period_q[1] <= wr_data;
                ADDR_MODE:  mode_q      <= wr_data[MODE_W-1:0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        period_o  = period_q;
        run_o     = mode_q[MB_RUN_LO +: NUM_TMR];
        flag_en_o = mode_q[MB_FLG_LO +: NUM_TMR];
        clr_o     = mode_wr ? wr_data[MB_CLR_LO +: NUM_TMR] : '0;
    end
endmodule

// File: rtl/dit_accum.sv
module dit_accum #(
    parameter int PER_W   = 16,
    parameter int TICK_W  = 4,
    parameter int STEP_SH = 6,
    parameter int ACC_W   = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [TICK_W-1:0] tick_n_i,
    input  logic [PER_W-1:0]  period_i,
    output logic              wrap_o,
    output logic [ACC_W-1:0]  acc_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] per_ext;
    logic             adv;
    logic             hit;

    always_comb begin
        adv     = run_i && (tick_n_i != '0);
        step    = ACC_W'(tick_n_i) << STEP_SH;
        per_ext = ACC_W'(period_i);
        sum     = acc_q + step;
        hit     = adv && (sum >= per_ext);
        if (hit) begin
            acc_d = sum - per_ext;
        end else if (adv) begin
            acc_d = sum;
        end else begin
            acc_d = acc_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign wrap_o = hit;
    assign acc_o  = acc_q;
endmodule

// File: rtl/dit_status.sv
module dit_status
    import dit_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] wrap_i,
    input  logic [NUM_TMR-1:0] flag_en_i,
    input  logic [NUM_TMR-1:0] clr_i,
    output logic [NUM_TMR-1:0] flags_o,
    output logic               irq_o
);
    logic [NUM_TMR-1:0] flags_q;
    logic [NUM_TMR-1:0] flags_d;
    irq_state_e         state_q;
    irq_state_e         state_d;

    always_comb begin
        for (int i = 0; i < NUM_TMR; i++) begin
            // set has priority over clear
            flags_d[i] = (flags_q[i] && !clr_i[i]) || (wrap_i[i] && flag_en_i[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (flags_q != '0) state_d = IRQ_RAISED;
            IRQ_RAISED: if (flags_q == '0) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        flags_o = flags_q;
        irq_o   = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/dual_ival_timer.sv
module dual_ival_timer
    import dit_pkg::*;
#(
    parameter int PER_W   = 16,
    parameter int TICK_W  = 4,
    parameter int STEP_SH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [PER_W-1:0]  wr_data,
    input  logic [TICK_W-1:0] tick_n,
    output logic [7:0]        status_o,
    output logic              irq_o
);
    localparam int STEP_W = TICK_W + STEP_SH;
    localparam int ACC_W  = ((PER_W > STEP_W) ? PER_W : STEP_W) + 1;

    logic [NUM_TMR-1:0][PER_W-1:0] period;
    logic [NUM_TMR-1:0]            run_en;
    logic [NUM_TMR-1:0]            flag_en;
    logic [NUM_TMR-1:0]            clr_req;
    logic [NUM_TMR-1:0]            wrap;
    logic [NUM_TMR-1:0][ACC_W-1:0] acc_vec;
    logic [NUM_TMR-1:0]            flags;

    dit_host_regs #(.PER_W(PER_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .period_o  (period),
        .run_o     (run_en),
        .flag_en_o (flag_en),
        .clr_o     (clr_req)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        dit_accum #(
            .PER_W   (PER_W),
            .TICK_W  (TICK_W),
            .STEP_SH (STEP_SH),
            .ACC_W   (ACC_W)
        ) u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_i    (run_en[t]),
            .tick_n_i (tick_n),
            .period_i (period[t]),
            .wrap_o   (wrap[t]),
            .acc_o    (acc_vec[t])
        );
    end

    dit_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap_i    (wrap),
        .flag_en_i (flag_en),
        .clr_i     (clr_req),
        .flags_o   (flags),
        .irq_o     (irq_o)
    );

    assign status_o = {{(8 - NUM_TMR){1'b0}}, flags};
endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
    parameter int PER_W  = 16,
    parameter int TICK_W = 4,
    parameter int ACC_W  = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [PER_W-1:0]      wr_data,
    input  logic [TICK_W-1:0]     tick_n,
    input  logic [7:0]            status_o,
    input  logic                  irq_o,
    input  logic [1:0]            run_en,
    input  logic [1:0][ACC_W-1:0] acc_vec
);
    logic clr_a_wr;
    logic clr_b_wr;
    assign clr_a_wr = wr_en && (wr_addr == 2'd2) && wr_data[4];
    assign clr_b_wr = wr_en && (wr_addr == 2'd2) && wr_data[5];

    // R1
    halted_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en[0] |=> $stable(acc_vec[0]));
    // R1
    halted_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en[1] |=> $stable(acc_vec[1]));
    // R6
    zero_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_n == '0) |=> $stable(acc_vec));
    // R6
    flag_a_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> ($past(tick_n) != '0));
    // R5
    flag_a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && !clr_a_wr) |=> status_o[0]);
    // R5
    flag_b_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[1] && !clr_b_wr) |=> status_o[1]);
    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[1:0] != 2'b00) |=> irq_o);
    // R9
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[1:0] == 2'b00) |=> !irq_o);
endmodule

bind dual_ival_timer dit_checker #(
    .PER_W  (PER_W),
    .TICK_W (TICK_W),
    .ACC_W  (ACC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tick_n   (tick_n),
    .status_o (status_o),
    .irq_o    (irq_o),
    .run_en   (run_en),
    .acc_vec  (acc_vec)
);

// File: tb/dual_ival_timer_test.sv
module dual_ival_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  tick_n = '0;
    logic [7:0]  status_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] st;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    // bench model
    int         acc_a = 0, acc_b = 0, per_a = 0, per_b = 0;
    logic [3:0] mode_m = '0;
    logic [1:0] st_m = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_ival_timer uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tick_n   (tick_n),
        .status_o (status_o),
        .irq_o    (irq_o)
    );

    task automatic check(input string tag, input logic [7:0] st, input logic irq,
                         input logic [7:0] st_e, input logic irq_e);
        checks++;
        if (st !== st_e || irq !== irq_e) begin
            failures++;
            $display("FAIL %s status=%02h irq=%b expected status=%02h irq=%b",
                     tag, st, irq, st_e, irq_e);
        end
    endtask

    // driver: one cycle of stimulus, pushes the state expected after the edge
    task automatic cyc(input int n, input bit we, input logic [1:0] a,
                       input logic [15:0] d, input string tag);
        logic [1:0] set;
        logic [1:0] clr;
        exp_t e;
        @(negedge clk);
        tick_n = 4'(n); wr_en = we; wr_addr = a; wr_data = d;
        e.irq = (st_m != 2'b00);
        set = 2'b00;
        if (n != 0 && mode_m[0]) begin
            acc_a += 64 * n;
            if (acc_a >= per_a) begin acc_a -= per_a; set[0] = mode_m[2]; end
        end
        if (n != 0 && mode_m[1]) begin
            acc_b += 64 * n;
            if (acc_b >= per_b) begin acc_b -= per_b; set[1] = mode_m[3]; end
        end
        clr = (we && a == 2'd2) ? d[5:4] : 2'b00;
        st_m = (st_m & ~clr) | set;
        if (we) begin
            case (a)
                2'd0: per_a = int'(d);
                2'd1: per_b = int'(d);
                2'd2: mode_m = d[3:0];
                default: ;
            endcase
        end
        e.st = {6'b0, st_m};
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, status_o, irq_o, e.st, e.irq);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10", status_o, irq_o, 8'h00, 1'b0);
        rst_n = 1'b1;

        // R8: load periods and mode, no ticks
        cyc(0, 1, 2'd0, 16'd200,  "R8");
        cyc(0, 1, 2'd1, 16'd1000, "R8");
        cyc(0, 1, 2'd2, 16'h0005, "R6");
        // R3: four unit ticks reach 256 >= 200, remainder 56
        for (int i = 0; i < 4; i++) cyc(1, 0, 2'd0, 16'd0, "R3");
        // R5 sticky, R9 irq follows
        cyc(0, 0, 2'd0, 16'd0, "R5");
        cyc(0, 0, 2'd0, 16'd0, "R9");
        // R7 clear A
        cyc(0, 1, 2'd2, 16'h0015, "R7");
        // R4: remainder makes next wrap after three ticks (248 -> 48)
        for (int i = 0; i < 3; i++) cyc(1, 0, 2'd0, 16'd0, "R4");
        // R7: clear and set in one cycle, set wins (48+192=240 -> 40)
        cyc(3, 1, 2'd2, 16'h0015, "R7");
        // R2: flag enable off, wraps leave flag clear (296->96, 352->152)
        cyc(0, 1, 2'd2, 16'h0011, "R2");
        cyc(4, 0, 2'd0, 16'd0, "R2");
        cyc(4, 0, 2'd0, 16'd0, "R2");
        // R1: both timers halted, flags enabled
        cyc(0, 1, 2'd2, 16'h000C, "R1");
        for (int i = 0; i < 3; i++) cyc(15, 0, 2'd0, 16'd0, "R1");
        // R1: resume A from held 152: 216 -> 16, flag set
        cyc(0, 1, 2'd2, 16'h000D, "R1");
        cyc(1, 0, 2'd0, 16'd0, "R1");
        // R8: period rewrite on a tick edge uses old period (16+192=208 -> 8)
        cyc(0, 1, 2'd2, 16'h001D, "R7");
        cyc(3, 1, 2'd0, 16'd1000, "R8");
        cyc(0, 1, 2'd2, 16'h001D, "R7");
        cyc(15, 0, 2'd0, 16'd0, "R8");
        cyc(1, 0, 2'd0, 16'd0, "R8");
        // R8: address 3 write ignored
        cyc(0, 1, 2'd3, 16'hFFFF, "R8");
        cyc(0, 0, 2'd0, 16'd0, "R8");
        // R3/R5: timer B alone with large ticks, flag in bit 1
        cyc(0, 1, 2'd2, 16'h003A, "R7");
        cyc(15, 0, 2'd0, 16'd0, "R3");
        cyc(15, 0, 2'd0, 16'd0, "R5");
        cyc(15, 0, 2'd0, 16'd0, "R4");
        // R9: irq drops one cycle after flags clear
        cyc(0, 1, 2'd2, 16'h002A, "R9");
        cyc(0, 0, 2'd0, 16'd0, "R9");
        cyc(0, 0, 2'd0, 16'd0, "R9");
        // R6: zero tick with timers running changes nothing
        cyc(0, 0, 2'd0, 16'd0, "R6");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule